// File: doc/BRIEF.md
# Single-Precision Float Compare Unit

This block compares two IEEE-754 single-precision operands under one of seven predicates and returns a one-bit answer widened with zeros to the result width. The caller presents both operands and a predicate code with a valid strobe. One clock later the block shows the answer, a per-operation invalid pulse, a sticky invalid bit and, if configured, an exception request.

Each operand is sorted as ordinary, zero, quiet NaN or signaling NaN. How a NaN affects the answer and the invalid flag depends on the predicate. The quiet predicates (equality, inequality, unordered) flag only signaling NaNs. The ordering predicates flag any NaN. Two predicates swap the operand order: less-than tests B < A, and greater-than tests A < B. Greater-or-equal is the complement of A < B, so it answers 1 for an unordered pair.

An exception request needs three things together: an invalid operation, the exception-configuration input and the exception-enable input. When a request fires, the cause output takes the floating-point cause code.

Top module: `sp_fcmp`

## Requirements
- R1: With code 0 (unordered) the result is 1 when either operand is a NaN, and 0 otherwise. Invalid is raised only when an operand is a signaling NaN.
- R2: Code 2 (equal) gives 1 for equal ordered operands. Code 5 (not-equal) is its exact complement, so a NaN operand gives 1. Both raise invalid only for a signaling NaN.
- R3: Code 1 (less-than) answers B < A. Code 4 (greater-than) answers A < B. Both answer 0 for a NaN operand and raise invalid for any NaN.
- R4: Code 3 (less-or-equal) answers A <= B. It gives 0 for a NaN operand and raises invalid for any NaN.
- R5: Code 6 (greater-or-equal) answers NOT (A < B), so a NaN operand gives 1. It raises invalid for any NaN.
- R6: +0 (0x00000000) and -0 (0x80000000) compare equal. A NaN has exponent bits 30..23 all ones and a nonzero fraction. It is quiet when bit 22 is 1 and signaling when bit 22 is 0. Infinities order as the extremes.
- R7: Code 7 is reserved. It yields result 0, no invalid pulse, no sticky change and no exception.
- R8: The outputs out_valid, result and invalid_flag appear on the clock edge after in_valid is sampled. The result's bits above bit 0 are always 0. out_valid is 0 in a cycle that follows no valid input.
- R9: invalid_sticky is set by any invalid operation and stays set until reset.
- R10: exc_req pulses with an invalid operation only when exc_cfg_en and exc_enable were both 1 with that input. On a request, exc_cause takes the cause code 6.
- R11: During and after reset, every output is 0 until a valid input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and predicate are presented |
| op_a | input | 32 | Operand A, single precision |
| op_b | input | 32 | Operand B, single precision |
| pred_sel | input | 3 | Predicate code 0..7 |
| exc_cfg_en | input | 1 | Floating-point exception configuration bit |
| exc_enable | input | 1 | Machine exception enable |
| out_valid | output | 1 | Result is presented |
| result | output | 32 | Comparison answer in bit 0, zeros above |
| invalid_flag | output | 1 | Invalid operation for this result |
| invalid_sticky | output | 1 | Sticky invalid status |
| exc_req | output | 1 | Exception request pulse |
| exc_cause | output | 5 | Cause code of the last request |

## Verification
The properties assume that pred_sel, op_a, op_b and both exception controls are stable and meaningful in every cycle where in_valid is high. They also assume that nothing is presented in the reset cycle that should be registered. The bench changes inputs only at the falling clock edge and raises in_valid for a single cycle per operation, so every input pattern is seen by exactly one rising edge. It then samples at the next falling edge. Reset is asserted again while inputs are idle, and the exception controls are changed only between operations.

// File: rtl/sp_fcmp_pkg.sv
package sp_fcmp_pkg;
   typedef enum logic [2:0] {
      PRED_UN  = 3'd0,
      PRED_LT  = 3'd1,
      PRED_EQ  = 3'd2,
      PRED_LE  = 3'd3,
      PRED_GT  = 3'd4,
      PRED_NE  = 3'd5,
      PRED_GE  = 3'd6,
      PRED_RSV = 3'd7
   } pred_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
   } fclass_t;
endpackage

// File: rtl/sp_fcmp_classify.sv
module sp_fcmp_classify
   import sp_fcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] val,
   output fclass_t      cls
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_max;
   logic              frac_nz;

   assign exp_f   = val[W-2 -: EXP_W];
   assign frac_f  = val[FRAC_W-1:0];
   assign exp_max = &exp_f;
   assign frac_nz = |frac_f;

   always_comb begin
      cls.is_nan  = exp_max & frac_nz;
      cls.is_snan = exp_max & frac_nz & ~frac_f[FRAC_W-1];
      cls.is_zero = ~|val[W-2:0];
   end
endmodule

// File: rtl/sp_fcmp_order.sv
module sp_fcmp_order #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         x_zero,
   input  logic         y_zero,
   output logic         x_lt_y
);
   logic         sx, sy;
   logic [W-2:0] mx, my;
   logic         both_zero;

   assign sx        = x[W-1];
   assign sy        = y[W-1];
   assign mx        = x[W-2:0];
   assign my        = y[W-2:0];
   assign both_zero = x_zero & y_zero;

   always_comb begin
      if (both_zero)
         x_lt_y = 1'b0;
      else if (sx != sy)
         x_lt_y = sx;
      else if (!sx)
         x_lt_y = (mx < my);
      else
         x_lt_y = (mx > my);
   end
endmodule

// File: rtl/sp_fcmp_core.sv
module sp_fcmp_core
   import sp_fcmp_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  fclass_t      cls_a,
   input  fclass_t      cls_b,
   input  logic [2:0]   sel,
   output logic         res,
   output logic         inv
);
   logic [1:0] lt_dir;   // [0]: a<b, [1]: b<a
   logic       any_nan, any_snan, ord_eq;

   for (genvar d = 0; d < 2; d++) begin : g_dir
      sp_fcmp_order #(.W(W)) u_ord (
         .x      (d == 0 ? a : b),
         .y      (d == 0 ? b : a),
         .x_zero (d == 0 ? cls_a.is_zero : cls_b.is_zero),
         .y_zero (d == 0 ? cls_b.is_zero : cls_a.is_zero),
         .x_lt_y (lt_dir[d])
      );
   end

   assign any_nan  = cls_a.is_nan | cls_b.is_nan;
   assign any_snan = cls_a.is_snan | cls_b.is_snan;
   assign ord_eq   = ~any_nan & ((a == b) | (cls_a.is_zero & cls_b.is_zero));

   always_comb begin
      res = 1'b0;
      inv = 1'b0;
      unique case (pred_e'(sel))
         PRED_UN:  begin res = any_nan;                  inv = any_snan; end
         PRED_LT:  begin res = ~any_nan & lt_dir[1];     inv = any_nan;  end
         PRED_EQ:  begin res = ord_eq;                   inv = any_snan; end
         PRED_LE:  begin res = ~any_nan & (lt_dir[0] | ord_eq); inv = any_nan; end
         PRED_GT:  begin res = ~any_nan & lt_dir[0];     inv = any_nan;  end
         PRED_NE:  begin res = ~ord_eq;                  inv = any_snan; end
         PRED_GE:  begin res = ~(~any_nan & lt_dir[0]);  inv = any_nan;  end
         PRED_RSV: begin res = 1'b0;                     inv = 1'b0;     end
      endcase
   end
endmodule

// File: rtl/sp_fcmp.sv
module sp_fcmp
   import sp_fcmp_pkg::*;
#(
   parameter int EXP_W       = 8,
   parameter int FRAC_W      = 23,
   parameter int OUT_W       = 32,
   parameter int CAUSE_W     = 5,
   parameter int CAUSE_FPU   = 6,
   parameter bit HOLD_RESULT = 1'b1,
   localparam int W          = 1 + EXP_W + FRAC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [W-1:0]       op_a,
   input  logic [W-1:0]       op_b,
   input  logic [2:0]         pred_sel,
   input  logic               exc_cfg_en,
   input  logic               exc_enable,
   output logic               out_valid,
   output logic [OUT_W-1:0]   result,
   output logic               invalid_flag,
   output logic               invalid_sticky,
   output logic               exc_req,
   output logic [CAUSE_W-1:0] exc_cause
);
   if (EXP_W < 2)                      begin : g_bad_exp   $error("EXP_W too small");   end
   if (FRAC_W < 2)                     begin : g_bad_frac  $error("FRAC_W too small");  end
   if (OUT_W < 1)                      begin : g_bad_out   $error("OUT_W too small");   end
   if (CAUSE_FPU >= (1 << CAUSE_W))    begin : g_bad_cause $error("cause code does not fit"); end

   fclass_t          cls [2];
   logic [W-1:0]     ops [2];
   logic             cmp_res, cmp_inv, take_exc;

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      sp_fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .val (ops[k]),
         .cls (cls[k])
      );
   end

   sp_fcmp_core #(.W(W)) u_core (
      .a     (op_a),
      .b     (op_b),
      .cls_a (cls[0]),
      .cls_b (cls[1]),
      .sel   (pred_sel),
      .res   (cmp_res),
      .inv   (cmp_inv)
   );

   assign take_exc = in_valid & cmp_inv & exc_cfg_en & exc_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         invalid_flag   <= 1'b0;
         invalid_sticky <= 1'b0;
         exc_req        <= 1'b0;
         exc_cause      <= '0;
      end else begin
         out_valid    <= in_valid;
         invalid_flag <= in_valid & cmp_inv;
         exc_req      <= take_exc;
         if (in_valid & cmp_inv) invalid_sticky <= 1'b1;
         if (take_exc)           exc_cause      <= CAUSE_W'(CAUSE_FPU);
      end
   end

   if (HOLD_RESULT) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        result <= '0;
         else if (in_valid) result <= OUT_W'(cmp_res);
      end
   end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) result <= '0;
         else        result <= in_valid ? OUT_W'(cmp_res) : '0;
      end
   end
endmodule

// File: rtl/sp_fcmp_chk.sv
module sp_fcmp_chk #(
   parameter int W         = 32,
   parameter int OUT_W     = 32,
   parameter int CAUSE_W   = 5,
   parameter int CAUSE_FPU = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [W-1:0]       op_a,
   input logic [W-1:0]       op_b,
   input logic [2:0]         pred_sel,
   input logic               exc_cfg_en,
   input logic               exc_enable,
   input logic               out_valid,
   input logic [OUT_W-1:0]   result,
   input logic               invalid_flag,
   input logic               invalid_sticky,
   input logic               exc_req,
   input logic [CAUSE_W-1:0] exc_cause
);
   logic a_nan, b_nan;
   assign a_nan = (&op_a[W-2 -: 8]) & (|op_a[W-10:0]);
   assign b_nan = (&op_b[W-2 -: 8]) & (|op_b[W-10:0]);

   p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (result >> 1) == '0);
   p_flag_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_flag |-> out_valid);
   p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_sticky |=> invalid_sticky);
   p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_flag |-> invalid_sticky);
   p_exc_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> invalid_flag && $past(exc_cfg_en && exc_enable));
   p_exc_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> exc_cause == CAUSE_W'(CAUSE_FPU));
   p_rsv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred_sel == 3'd7) |=> (!invalid_flag && result == '0));
   p_un_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred_sel == 3'd0 && (a_nan || b_nan)) |=> result[0]);
endmodule

bind sp_fcmp sp_fcmp_chk #(
   .W(W), .OUT_W(OUT_W), .CAUSE_W(CAUSE_W), .CAUSE_FPU(CAUSE_FPU)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
   .pred_sel(pred_sel), .exc_cfg_en(exc_cfg_en), .exc_enable(exc_enable),
   .out_valid(out_valid), .result(result), .invalid_flag(invalid_flag),
   .invalid_sticky(invalid_sticky), .exc_req(exc_req), .exc_cause(exc_cause)
);

// File: tb/sp_fcmp_tb.sv
module sp_fcmp_tb_top;
   localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
   localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
   localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
   localparam logic [31:0] PI = 32'h7F80_0000, NI = 32'hFF80_0000;
   localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;

   // {sel, a, b, expected result, expected invalid}
   localparam int NV = 30;
   localparam logic [68:0] VEC [NV] = '{
      {3'd0, P1, P2, 1'b0, 1'b0}, {3'd0, QN, P1, 1'b1, 1'b0},
      {3'd0, P1, SN, 1'b1, 1'b1},
      {3'd1, P2, P1, 1'b1, 1'b0}, {3'd1, P1, P2, 1'b0, 1'b0},
      {3'd1, QN, P1, 1'b0, 1'b1}, {3'd1, N1, N2, 1'b1, 1'b0},
      {3'd2, PZ, NZ, 1'b1, 1'b0}, {3'd2, QN, QN, 1'b0, 1'b0},
      {3'd2, SN, P1, 1'b0, 1'b1}, {3'd2, P1, P1, 1'b1, 1'b0},
      {3'd3, P1, P2, 1'b1, 1'b0}, {3'd3, P2, P2, 1'b1, 1'b0},
      {3'd3, P2, P1, 1'b0, 1'b0}, {3'd3, QN, P1, 1'b0, 1'b1},
      {3'd4, P1, P2, 1'b1, 1'b0}, {3'd4, P2, P1, 1'b0, 1'b0},
      {3'd4, N1, P1, 1'b1, 1'b0}, {3'd4, NI, N1, 1'b1, 1'b0},
      {3'd4, N1, NI, 1'b0, 1'b0}, {3'd4, P2, PI, 1'b1, 1'b0},
      {3'd5, P1, P1, 1'b0, 1'b0}, {3'd5, QN, P1, 1'b1, 1'b0},
      {3'd5, SN, SN, 1'b1, 1'b1},
      {3'd6, P2, P1, 1'b1, 1'b0}, {3'd6, P1, P2, 1'b0, 1'b0},
      {3'd6, QN, P1, 1'b1, 1'b1}, {3'd6, NZ, PZ, 1'b1, 1'b0},
      {3'd7, SN, SN, 1'b0, 1'b0}, {3'd7, P1, P1, 1'b0, 1'b0}
   };

   logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [2:0]  pred_sel = '0;
   logic        exc_cfg_en = 1'b0, exc_enable = 1'b0;
   logic        out_valid, invalid_flag, invalid_sticky, exc_req;
   logic [31:0] result;
   logic [4:0]  exc_cause;
   int          total = 0, fails = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   sp_fcmp dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .pred_sel(pred_sel), .exc_cfg_en(exc_cfg_en), .exc_enable(exc_enable),
      .out_valid(out_valid), .result(result), .invalid_flag(invalid_flag),
      .invalid_sticky(invalid_sticky), .exc_req(exc_req), .exc_cause(exc_cause)
   );

   function automatic string req_of(logic [2:0] s);
      case (s)
         3'd0: return "R1";
         3'd1, 3'd4: return "R3";
         3'd2, 3'd5: return "R2";
         3'd3: return "R4";
         3'd6: return "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one-cycle operation; outputs sampled at the next falling edge
   task automatic apply(logic [2:0] s, logic [31:0] a, logic [31:0] b);
      @(negedge clk);
      pred_sel = s; op_a = a; op_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", {26'd0, out_valid, invalid_flag, invalid_sticky, exc_req, exc_cause == 5'd0}, 32'h1);
      chk("R11", result, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][68:66], VEC[i][65:34], VEC[i][33:2]);
         chk(req_of(VEC[i][68:66]), result, {31'd0, VEC[i][1]});  // R6 zeros/NaN encodings inside table
         chk(req_of(VEC[i][68:66]), {31'd0, invalid_flag}, {31'd0, VEC[i][0]});
         chk("R8", {31'd0, out_valid}, 32'h1);
         chk("R10", {31'd0, exc_req}, 32'h0);
      end

      @(negedge clk);
      chk("R8", {31'd0, out_valid}, 32'h0);
      chk("R9", {31'd0, invalid_sticky}, 32'h1);

      // R9: sticky starts clear, survives a clean op once set
      rst_n = 1'b0; @(negedge clk);
      chk("R11", {31'd0, invalid_sticky}, 32'h0);
      chk("R11", result, 32'h0);
      rst_n = 1'b1;
      apply(3'd2, PZ, NZ);
      chk("R6", result, 32'h1);
      chk("R9", {31'd0, invalid_sticky}, 32'h0);
      apply(3'd7, SN, QN);
      chk("R7", {31'd0, invalid_sticky}, 32'h0);
      apply(3'd3, SN, P1);
      chk("R9", {31'd0, invalid_sticky}, 32'h1);
      apply(3'd2, P1, P1);
      chk("R9", {31'd0, invalid_sticky}, 32'h1);

      // R10: exception gating
      exc_cfg_en = 1'b1; exc_enable = 1'b0;
      apply(3'd1, QN, P1);
      chk("R10", {31'd0, exc_req}, 32'h0);
      chk("R10", {27'd0, exc_cause}, 32'h0);
      exc_cfg_en = 1'b0; exc_enable = 1'b1;
      apply(3'd1, QN, P1);
      chk("R10", {31'd0, exc_req}, 32'h0);
      exc_cfg_en = 1'b1;
      apply(3'd5, QN, P1);   // quiet predicate, quiet NaN: no invalid
      chk("R10", {31'd0, exc_req}, 32'h0);
      apply(3'd1, QN, P1);
      chk("R10", {31'd0, exc_req}, 32'h1);
      chk("R10", {27'd0, exc_cause}, 32'd6);
      @(negedge clk);
      chk("R10", {31'd0, exc_req}, 32'h0);
      chk("R10", {27'd0, exc_cause}, 32'd6);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule